// File: doc/BRIEF.md
# Serial Measurement Register Reader

This block is a read-only serial slave that lets a host fetch four 24-bit measurement words (active energy, reactive energy, mains voltage, mains frequency). The words arrive on parallel input ports. The host raises chip select and clocks a command in on the data input, one bit per rising serial-clock edge. The command is the three-bit header `1,1,0` followed by a six-bit register address. Any number of zero bits may come before the header. After the address, the block shifts the chosen word out, most significant bit first. If the host keeps clocking, the following words come out back to back.

The serial pins are sampled in the system clock domain: `sck_i`, `cs_i` and `di_i` are taken as already synchronous to `clk`, and a rising serial edge is seen on the first `clk` edge at which `sck_i` is high after being low. The serial link has no back-pressure. The host sets the pace through its clock edges, and the block accepts or presents one bit on each detected edge. The data output is meant to go high-impedance when chip select is low. That is represented by a separate enable, `do_oe_o`.

Top module: `spi_meas_reader`

## Requirements
- R1: With `cs_i` low, `do_oe_o` is 0 and `do_o` is 0 from the next `clk` edge. With `cs_i` high, `do_oe_o` is 1.
- R2: `di_i` is taken only on a detected rising edge of `sck_i` while `cs_i` is high. Serial clock edges while `cs_i` is low have no effect.
- R3: Address bits A5 and A4 (the first two address bits sent) do not affect which register is selected.
- R4: The low four address bits A3..A0 select the register: 0000 active energy, 0001 reactive energy, 0010 voltage, 1011 frequency.
- R5: On the serial edge that takes in A0, `do_o` is 0. The next serial edge presents the MSB of the selected word.
- R6: Each word is 24 bits, presented MSB first, one bit per serial edge.
- R7: After a word's last bit, the next edge presents the MSB of the next word in the order active energy, reactive energy, voltage, frequency, then back to active energy.
- R8: An address that decodes to no register yields 24 zero bits, followed by active energy and the normal order.
- R9: Dropping `cs_i` clears the command search and the output stream. After `cs_i` rises again, nothing is streamed until a complete new command arrives.
- R10: A word is captured from its input port on the edge that presents its MSB. Changes to that port later in the word do not alter the bits sent.
- R11: Leading zero bits are skipped. The header is the first occurrence of `1,1,0` in the bit stream, so false starts such as `1,0` or `1,1,1` resolve correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_i | input | 1 | Chip select, active high |
| sck_i | input | 1 | Serial clock from the host |
| di_i | input | 1 | Serial command input |
| act_energy_i | input | 24 | Active energy word |
| react_energy_i | input | 24 | Reactive energy word |
| volt_i | input | 24 | Mains voltage word |
| freq_i | input | 24 | Mains frequency word |
| do_o | output | 1 | Serial data output |
| do_oe_o | output | 1 | Output enable for the serial data pin |

## Verification
The bench sends commands padded with a varying number of zeros, and commands with false header starts. A detector that does not follow the first `1,1,0` would either lock onto the wrong address or never start. It reads across word boundaries and through the wrap from frequency back to active energy, which catches off-by-one bit counters and a wrong successor order. It changes a source word in the middle of its transfer to expose a design that shifts live port data instead of a captured copy. It also toggles the serial clock with chip select low, and drops chip select mid-stream, to expose state that survives deselection.

// File: rtl/spi_meas_pkg.sv
package spi_meas_pkg;

  localparam int NUM_REGS = 4;
  localparam int ADDR_W   = 6;
  localparam int NIB_W    = 4;
  localparam int SEL_W    = 3;
  localparam logic [SEL_W-1:0] SEL_NONE = SEL_W'(NUM_REGS);

  typedef enum logic [2:0] {
    HS_SEEK,
    HS_ONE,
    HS_ONEONE,
    HS_ADDR,
    HS_DONE
  } hdr_state_e;

  // Map the low address nibble onto a register slot; unknown codes -> SEL_NONE.
  function automatic logic [SEL_W-1:0] decode_nib(input logic [NIB_W-1:0] nib);
    case (nib)
      4'b0000: return SEL_W'(0);
      4'b0001: return SEL_W'(1);
      4'b0010: return SEL_W'(2);
      4'b1011: return SEL_W'(3);
      default: return SEL_NONE;
    endcase
  endfunction

  // Successor slot: the last valid slot and the empty slot both go to slot 0.
  function automatic logic [SEL_W-1:0] next_sel(input logic [SEL_W-1:0] s);
    if (s >= SEL_W'(NUM_REGS - 1)) return '0;
    return s + SEL_W'(1);
  endfunction

endpackage

// File: rtl/sck_edge_det.sv
module sck_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_i,
  input  logic sck_i,
  output logic rise_o
);
  logic sck_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_q <= 1'b0;
    else        sck_q <= sck_i;
  end

  // Only edges seen while selected count.
  assign rise_o = cs_i & sck_i & ~sck_q;
endmodule

// File: rtl/hdr_addr_det.sv
module hdr_addr_det
  import spi_meas_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_i,
  input  logic             rise_i,
  input  logic             di_i,
  output logic             hit_o,
  output logic [NIB_W-1:0] nib_o,
  output hdr_state_e       st_o
);
  localparam int ACNT_W = $clog2(ADDR_W);

  hdr_state_e        st;
  logic [ACNT_W-1:0] acnt;
  logic [NIB_W-2:0]  ash;   // only A3..A1 are retained; A5/A4 fall off

  assign hit_o = rise_i && (st == HS_ADDR) && (acnt == ACNT_W'(ADDR_W - 1));
  assign nib_o = {ash, di_i};
  assign st_o  = st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= HS_SEEK;
      acnt <= '0;
      ash  <= '0;
    end else if (!cs_i) begin
      st   <= HS_SEEK;
      acnt <= '0;
      ash  <= '0;
    end else if (rise_i) begin
      case (st)
        HS_SEEK:   st <= di_i ? HS_ONE : HS_SEEK;
        HS_ONE:    st <= di_i ? HS_ONEONE : HS_SEEK;
        HS_ONEONE: begin
          if (!di_i) begin
            st   <= HS_ADDR;
            acnt <= '0;
          end
        end
        HS_ADDR: begin
          ash <= {ash[NIB_W-3:0], di_i};
          if (acnt == ACNT_W'(ADDR_W - 1)) st <= HS_DONE;
          else                             acnt <= acnt + ACNT_W'(1);
        end
        default: st <= HS_DONE;
      endcase
    end
  end
endmodule

// File: rtl/word_streamer.sv
module word_streamer
  import spi_meas_pkg::*;
#(
  parameter int WORD_W = 24
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             cs_i,
  input  logic                             rise_i,
  input  logic                             hit_i,
  input  logic [NIB_W-1:0]                 nib_i,
  input  logic [NUM_REGS-1:0][WORD_W-1:0]  words_i,
  output logic                             do_o,
  output logic                             active_o
);
  localparam int CNT_W = $clog2(WORD_W);

  logic              active;
  logic [SEL_W-1:0]  sel;
  logic [CNT_W-1:0]  cnt;      // bits still to present in the current word
  logic [WORD_W-1:0] sh;
  logic              do_q;
  logic [WORD_W-1:0] cur_word;

  always_comb begin
    cur_word = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (sel == SEL_W'(i)) cur_word = words_i[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      sel    <= '0;
      cnt    <= '0;
      sh     <= '0;
      do_q   <= 1'b0;
    end else if (!cs_i) begin
      active <= 1'b0;
      sel    <= '0;
      cnt    <= '0;
      sh     <= '0;
      do_q   <= 1'b0;
    end else if (rise_i) begin
      if (hit_i) begin
        active <= 1'b1;
        sel    <= decode_nib(nib_i);
        cnt    <= '0;
        do_q   <= 1'b0;
      end else if (active) begin
        if (cnt == '0) begin
          do_q <= cur_word[WORD_W-1];
          sh   <= {cur_word[WORD_W-2:0], 1'b0};
          cnt  <= CNT_W'(WORD_W - 1);
        end else begin
          do_q <= sh[WORD_W-1];
          sh   <= {sh[WORD_W-2:0], 1'b0};
          cnt  <= cnt - CNT_W'(1);
          if (cnt == CNT_W'(1)) sel <= next_sel(sel);
        end
      end
    end
  end

  assign do_o     = do_q;
  assign active_o = active;
endmodule

// File: rtl/spi_meas_reader.sv
module spi_meas_reader
  import spi_meas_pkg::*;
#(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_i,
  input  logic              sck_i,
  input  logic              di_i,
  input  logic [WORD_W-1:0] act_energy_i,
  input  logic [WORD_W-1:0] react_energy_i,
  input  logic [WORD_W-1:0] volt_i,
  input  logic [WORD_W-1:0] freq_i,
  output logic              do_o,
  output logic              do_oe_o
);
  logic                            sck_rise;
  logic                            hit;
  logic [NIB_W-1:0]                nib;
  hdr_state_e                      hdr_st;
  logic                            stream_on;
  logic [NUM_REGS-1:0][WORD_W-1:0] words;

  assign words[0] = act_energy_i;
  assign words[1] = react_energy_i;
  assign words[2] = volt_i;
  assign words[3] = freq_i;

  sck_edge_det u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .cs_i   (cs_i),
    .sck_i  (sck_i),
    .rise_o (sck_rise)
  );

  hdr_addr_det u_det (
    .clk    (clk),
    .rst_n  (rst_n),
    .cs_i   (cs_i),
    .rise_i (sck_rise),
    .di_i   (di_i),
    .hit_o  (hit),
    .nib_o  (nib),
    .st_o   (hdr_st)
  );

  word_streamer #(.WORD_W(WORD_W)) u_stream (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_i     (cs_i),
    .rise_i   (sck_rise),
    .hit_i    (hit),
    .nib_i    (nib),
    .words_i  (words),
    .do_o     (do_o),
    .active_o (stream_on)
  );

  assign do_oe_o = cs_i;
endmodule

// File: rtl/spi_meas_reader_chk.sv
module spi_meas_reader_chk
  import spi_meas_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       cs_i,
  input logic       sck_rise,
  input logic       hit,
  input logic       do_o,
  input logic       stream_on,
  input hdr_state_e hdr_st
);
  // R1
  deselect_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_i |=> (do_o == 1'b0));

  // R5
  a0_edge_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (do_o == 1'b0) && stream_on);

  // R6
  hold_between_edges_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_i && !sck_rise) |=> $stable(do_o));

  // R2
  search_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_i && !sck_rise) |=> $stable(hdr_st));

  // R9
  deselect_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_i |=> !stream_on && (hdr_st == HS_SEEK));

  // R5
  stream_after_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_st != HS_DONE) |-> !stream_on);
endmodule

bind spi_meas_reader spi_meas_reader_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs_i      (cs_i),
  .sck_rise  (sck_rise),
  .hit       (hit),
  .do_o      (do_o),
  .stream_on (stream_on),
  .hdr_st    (hdr_st)
);

// File: tb/spi_meas_reader_bench.sv
`timescale 1ns/1ps
module spi_meas_reader_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0, sck = 1'b0, di = 1'b0;
  logic [23:0] act_v = 24'hA5C3F1, react_v = 24'h5E1297;
  logic [23:0] volt_v = 24'hC0FFEE, freq_v = 24'h8A0C31;
  logic do_w, oe_w;

  int checks = 0, fails = 0;
  bit run = 0, done = 0;
  string cur_tag = "R1";

  // behavioural reference state
  bit hist[$];
  bit mstream = 0;
  int mstart = 0;
  int k = 0;
  logic [23:0] cap = '0;
  logic exp_do = 1'b0, exp_oe = 1'b0;

  always #10 clk = ~clk;

  spi_meas_reader u_spi_meas_reader (
    .clk(clk), .rst_n(rst_n), .cs_i(cs), .sck_i(sck), .di_i(di),
    .act_energy_i(act_v), .react_energy_i(react_v), .volt_i(volt_v), .freq_i(freq_v),
    .do_o(do_w), .do_oe_o(oe_w)
  );

  task automatic chk(input string tag, input logic [23:0] got, input logic [23:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic logic [23:0] reg_by_idx(input int i);
    case (i)
      0: return act_v;
      1: return react_v;
      2: return volt_v;
      default: return freq_v;
    endcase
  endfunction

  // R4 map; 4 = no register
  function automatic int decode_ref(input logic [3:0] n);
    if (n == 4'b0000) return 0;
    if (n == 4'b0001) return 1;
    if (n == 4'b0010) return 2;
    if (n == 4'b1011) return 3;
    return 4;
  endfunction

  function automatic logic [23:0] word_src(input int s, input int w);
    if (s == 4) return (w == 0) ? 24'h0 : reg_by_idx((w - 1) % 4);
    return reg_by_idx((s + w) % 4);
  endfunction

  task automatic model_bit(input bit b);
    hist.push_back(b);
    if (!mstream) begin
      int p = -1;
      for (int i = 0; i + 2 < hist.size(); i++)
        if (hist[i] && hist[i+1] && !hist[i+2]) begin p = i; break; end
      if (p >= 0 && hist.size() == p + 9) begin
        logic [3:0] n;
        n = {hist[p+5], hist[p+6], hist[p+7], hist[p+8]};
        mstart = decode_ref(n);
        mstream = 1;
        k = -1;
        exp_do = 1'b0;
      end
    end else begin
      k++;
      if (k % 24 == 0) cap = word_src(mstart, k / 24);
      exp_do = cap[23 - (k % 24)];
    end
  endtask

  always @(negedge clk) begin
    if (run) begin
      chk({cur_tag, " do_o per-cycle"}, {23'h0, do_w}, {23'h0, exp_do});
      chk("R1 do_oe per-cycle", {23'h0, oe_w}, {23'h0, exp_oe});
    end
  end

  task automatic clk_bit(input bit b);
    @(posedge clk); #2; di = b; sck = 1'b0;
    @(posedge clk); #2; sck = 1'b1;
    @(posedge clk); #1;
    if (cs) model_bit(b);
  endtask

  task automatic cs_on();
    @(posedge clk); #2; cs = 1'b1; exp_oe = 1'b1;
    @(posedge clk); #1;
  endtask

  task automatic cs_off();
    @(posedge clk); #2; cs = 1'b0; exp_oe = 1'b0;
    @(posedge clk); #1;
    hist.delete(); mstream = 0; exp_do = 1'b0;
  endtask

  task automatic send_cmd(input int pad, input logic [5:0] a);
    for (int i = 0; i < pad; i++) clk_bit(1'b0);
    clk_bit(1'b1); clk_bit(1'b1); clk_bit(1'b0);
    for (int i = 5; i >= 0; i--) clk_bit(a[i]);
  endtask

  task automatic read_word(output logic [23:0] v);
    v = '0;
    for (int i = 0; i < 24; i++) begin
      clk_bit(1'b0);
      v = {v[22:0], do_w};
    end
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [23:0] v;
    logic [23:0] old;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset do_oe", {23'h0, oe_w}, 24'h0);
    chk("R1 reset do_o", {23'h0, do_w}, 24'h0);
    rst_n = 1'b1;
    run = 1;

    // padded single read, then streaming with wrap
    cur_tag = "R6"; cs_on();
    send_cmd(7, 6'b000000);
    chk("R5 low after A0", {23'h0, do_w}, 24'h0);
    read_word(v); chk("R6 R2 active energy", v, act_v);
    cur_tag = "R7";
    read_word(v); chk("R7 reactive next", v, react_v);
    read_word(v); chk("R7 voltage next", v, volt_v);
    read_word(v); chk("R7 frequency next", v, freq_v);
    read_word(v); chk("R7 wrap to active", v, act_v);
    clk_bit(1'b0);
    cs_off();
    chk("R1 oe low off", {23'h0, oe_w}, 24'h0);

    // R9: reselect, no command -> nothing streams
    cur_tag = "R9"; cs_on();
    read_word(v); chk("R9 no stream without command", v, 24'h0);
    cs_off();

    // R3 R4: A5/A4 set, nibble 0010 -> voltage
    cur_tag = "R3"; cs_on();
    send_cmd(0, 6'b110010);
    read_word(v); chk("R3 R4 voltage with A5A4 set", v, volt_v);
    cs_off();

    // R4: frequency then wrap
    cur_tag = "R4"; cs_on();
    send_cmd(3, 6'b001011);
    read_word(v); chk("R4 frequency decode", v, freq_v);
    read_word(v); chk("R7 frequency wraps to active", v, act_v);
    cs_off();

    // R8: undefined address
    cur_tag = "R8"; cs_on();
    send_cmd(1, 6'b000101);
    read_word(v); chk("R8 undefined gives zeros", v, 24'h0);
    read_word(v); chk("R8 then active energy", v, act_v);
    cs_off();

    // R11: false starts 1,0 then 1,1,1,0
    cur_tag = "R11"; cs_on();
    clk_bit(1'b0); clk_bit(1'b1); clk_bit(1'b0);
    clk_bit(1'b1);
    send_cmd(0, 6'b000001);
    read_word(v); chk("R11 false start reactive", v, react_v);
    cs_off();

    // R10: source changes mid-word
    cur_tag = "R10"; cs_on();
    send_cmd(2, 6'b000001);
    old = react_v;
    clk_bit(1'b0); v = {23'h0, do_w};
    @(posedge clk); #2; react_v = ~old;
    for (int i = 0; i < 23; i++) begin clk_bit(1'b0); v = {v[22:0], do_w}; end
    chk("R10 latched word", v, old);
    read_word(v); chk("R10 next word voltage", v, volt_v);
    cs_off();
    react_v = old;

    // R2: clocking with chip select low is ignored
    cur_tag = "R2";
    clk_bit(1'b1); clk_bit(1'b1); clk_bit(1'b0);
    for (int i = 0; i < 6; i++) clk_bit(1'b0);
    cs_on();
    read_word(v); chk("R2 deselected edges ignored", v, 24'h0);
    cs_off();

    run = 0;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule